// File: doc/BRIEF.md
# Codec Control Register Shadow and Serial Word Writer

This block keeps a local copy of the 24 control registers of an audio codec (9 bits each) and turns every accepted register update into a 16-bit control word. Each word is handed, most significant byte first, to an external two-wire byte sender over a request/acknowledge byte handshake. The host can write any register directly, or give the left and right volume of the playback or capture path as a step value from 0 to 128.

A volume request is converted into attenuation codes and compared with the local copy. Channels whose code has not changed produce no traffic. A changed playback channel is sent twice: first as a plain store and then as a latch word, so that both output channels take effect together. Words wait in a small queue. A busy flag covers everything that is queued or being sent. Reads return the stored register contents, and a separate read port reports the stored volume of either path as steps.

Top module: `codec_shadow_writer`

## Requirements
- R1: After reset every stored register reads 0, `busy` and `tx_req` are low, `ready` is high and both volume read-back steps are 0.
- R2: An accepted register write to address A (0x00 to 0x17) stores the low 9 bits of the data. The value read at `rd_addr` appears on `rd_data` one cycle later. Addresses above 0x17 read as 0.
- R3: Each queued word is {address[6:0], data[8:0]} and is sent as two bytes, bits 15:8 first and bits 7:0 second. `tx_req` stays high with `tx_byte` unchanged until `tx_ack` is seen.
- R4: A register write to an address above 0x17, or with data above 0xFFFF (bit 16 set), stores nothing and sends nothing.
- R5: Playback code: step 0 gives 0x00 and step v gives v+127, so step 128 gives 0xFF. Steps above 128 are treated as 128.
- R6: Capture code: step 0 gives 0x00 and step v gives v+79, so step 128 gives 0xCF. Steps above 128 are treated as 128.
- R7: Volume read-back reports, per channel, 0 when the stored low 8 bits are at or below the path offset (127 playback, 79 capture), and otherwise the stored value minus the offset. Left is register 0x03 (playback) or 0x0E (capture); right is the next address.
- R8: A volume channel whose stored low 8 bits already equal the new code is skipped: nothing is stored or sent for it.
- R9: A changed playback channel stores {0, code} and queues two words, the second with data bit 8 set. The order is left, left-latch, right, right-latch. The latch word does not change the stored value.
- R10: A changed capture channel queues one word, left before right.
- R11: Words go out in acceptance order. `busy` is high from the cycle after acceptance until the low byte of the last pending word has been acknowledged.
- R12: `ready` is high while at least 4 queue slots are free. Any host write presented while `ready` is low is ignored. When both write enables are high, only the register write is considered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Direct register write strobe |
| reg_wr_addr | input | 8 | Register address of the direct write |
| reg_wr_data | input | 17 | Data of the direct write |
| vol_wr_en | input | 1 | Volume write strobe |
| vol_wr_path | input | 1 | 0 playback, 1 capture |
| vol_wr_left | input | 8 | Left step value |
| vol_wr_right | input | 8 | Right step value |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 9 | Stored register value, one cycle after `rd_addr` |
| vol_rd_path | input | 1 | Path chosen for volume read-back |
| vol_rd_left | output | 8 | Left read-back step |
| vol_rd_right | output | 8 | Right read-back step |
| ready | output | 1 | Room for a further host request |
| busy | output | 1 | Words pending or in transmission |
| tx_req | output | 1 | Byte request to the two-wire sender |
| tx_byte | output | 8 | Byte to send |
| tx_ack | input | 1 | Byte accepted by the sender |

## Verification
Volume requests run from a table that walks both paths through first use, exact repeats, a single-channel change, clamped steps and mute. The queued word count tells skipped channels from sent ones, and the byte order tells latch words from plain stores. Direct writes cover in-range, out-of-range address, oversized data and data wider than nine bits, which separates storing from ignoring. A held acknowledge checks the byte hold and fills the queue until `ready` drops. Read-back of the values 0x7F and 0x80 places the offset boundary exactly.

// File: rtl/codec_shadow_pkg.sv
package codec_shadow_pkg;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int MAX_PUSH = 4;
  localparam int PUSH_CW  = $clog2(MAX_PUSH + 1);
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {PATH_PLAY = 1'b0, PATH_CAPT = 1'b1} vol_path_e;
endpackage

// File: rtl/vol_map.sv
module vol_map import codec_shadow_pkg::*; #(
  parameter int STEP_W     = 8,
  parameter int STEP_FULL  = 128,
  parameter int PB_OFFSET  = 127,
  parameter int CAP_OFFSET = 79,
  parameter int FIELD_W    = 7,
  parameter int CODE_W     = 8
) (
  input  logic               path,
  input  logic [STEP_W-1:0]  step_l,
  input  logic [STEP_W-1:0]  step_r,
  input  logic [CODE_W-1:0]  cur_l,
  input  logic [CODE_W-1:0]  cur_r,
  input  logic [FIELD_W-1:0] addr_l,
  output logic [CODE_W-1:0]  code_l,
  output logic [CODE_W-1:0]  code_r,
  output logic               chg_l,
  output logic               chg_r,
  output word_t              words [MAX_PUSH],
  output logic [PUSH_CW-1:0] n_words
);
  localparam int ADDR_HI = FIELD_W;

  function automatic logic [CODE_W-1:0] map_step(input logic [STEP_W-1:0] s, input logic p);
    int v;
    int off;
    v   = (int'(s) > STEP_FULL) ? STEP_FULL : int'(s);
    off = (p == PATH_CAPT) ? CAP_OFFSET : PB_OFFSET;
    return (v == 0) ? '0 : CODE_W'(v + off);
  endfunction

  logic [FIELD_W-1:0] addr_r;
  assign addr_r = FIELD_W'(addr_l + 1'b1);

  always_comb begin
    int idx;
    code_l = map_step(step_l, path);
    code_r = map_step(step_r, path);
    chg_l  = (code_l != cur_l);
    chg_r  = (code_r != cur_r);
    for (int i = 0; i < MAX_PUSH; i++) words[i] = '0;
    idx = 0;
    if (chg_l) begin
      words[idx] = {addr_l, 1'b0, code_l};
      idx++;
      if (path == PATH_PLAY) begin
        words[idx] = {addr_l, 1'b1, code_l};
        idx++;
      end
    end
    if (chg_r) begin
      words[idx] = {addr_r, 1'b0, code_r};
      idx++;
      if (path == PATH_PLAY) begin
        words[idx] = {addr_r, 1'b1, code_r};
        idx++;
      end
    end
    n_words = PUSH_CW'(idx);
  end
endmodule

// File: rtl/cmd_fifo.sv
module cmd_fifo import codec_shadow_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PUSH_CW-1:0] push_n,
  input  word_t              push_words [MAX_PUSH],
  input  logic               pop,
  output word_t              head,
  output logic               empty,
  output logic               room
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  word_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_PUSH; i++)
      if (PUSH_CW'(i) < push_n) mem[wr_ptr + PTR_W'(i)] <= push_words[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count  <= count + CNT_W'(push_n) - CNT_W'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign room  = (count <= CNT_W'(DEPTH - MAX_PUSH));

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/byte_tx.sv
module byte_tx import codec_shadow_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  word_t             q_head,
  output logic              pop,
  output logic              active,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ack
);
  word_t cur;
  logic  low_phase;

  assign pop     = (!active || (tx_ack && low_phase)) && !q_empty;
  assign tx_byte = low_phase ? cur[BYTE_W-1:0] : cur[WORD_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      low_phase <= 1'b0;
      cur       <= '0;
    end else if (pop) begin
      cur       <= q_head;
      active    <= 1'b1;
      low_phase <= 1'b0;
    end else if (active && tx_ack) begin
      if (!low_phase) low_phase <= 1'b1;
      else            active    <= 1'b0;
    end
  end

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (active && !tx_ack) |=> (active && $stable(tx_byte)));
  a_r3_high_then_low: assert property (@(posedge clk) disable iff (rst)
    (active && tx_ack && !low_phase) |=> (active && tx_byte == $past(cur[BYTE_W-1:0])));
endmodule

// File: rtl/codec_shadow_writer.sv
module codec_shadow_writer import codec_shadow_pkg::*; #(
  parameter int NUM_REGS   = 24,
  parameter int REG_W      = 9,
  parameter int HADDR_W    = 8,
  parameter int HDATA_W    = 17,
  parameter int STEP_W     = 8,
  parameter int STEP_FULL  = 128,
  parameter int PB_OFFSET  = 127,
  parameter int CAP_OFFSET = 79,
  parameter int PB_LEFT    = 3,
  parameter int CAP_LEFT   = 14,
  parameter int QDEPTH     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic [HADDR_W-1:0] reg_wr_addr,
  input  logic [HDATA_W-1:0] reg_wr_data,
  input  logic               vol_wr_en,
  input  logic               vol_wr_path,
  input  logic [STEP_W-1:0]  vol_wr_left,
  input  logic [STEP_W-1:0]  vol_wr_right,
  input  logic [HADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic               vol_rd_path,
  output logic [STEP_W-1:0]  vol_rd_left,
  output logic [STEP_W-1:0]  vol_rd_right,
  output logic               ready,
  output logic               busy,
  output logic               tx_req,
  output logic [BYTE_W-1:0]  tx_byte,
  input  logic               tx_ack
);
  localparam int RIDX_W  = $clog2(NUM_REGS);
  localparam int FIELD_W = WORD_W - REG_W;
  localparam int CODE_W  = REG_W - 1;

  logic [REG_W-1:0] shadow [NUM_REGS];

  // request acceptance
  logic reg_in_range, reg_ok, vol_ok;
  assign reg_in_range = (reg_wr_addr < HADDR_W'(NUM_REGS)) &&
                        (reg_wr_data[HDATA_W-1:WORD_W] == '0);
  assign reg_ok = reg_wr_en && ready && reg_in_range;
  assign vol_ok = vol_wr_en && !reg_wr_en && ready;

  logic [RIDX_W-1:0] vol_base, vol_base_r, rd_vbase;
  assign vol_base   = (vol_wr_path == PATH_CAPT) ? RIDX_W'(CAP_LEFT) : RIDX_W'(PB_LEFT);
  assign vol_base_r = RIDX_W'(vol_base + 1'b1);
  assign rd_vbase   = (vol_rd_path == PATH_CAPT) ? RIDX_W'(CAP_LEFT) : RIDX_W'(PB_LEFT);

  // volume conversion
  logic [CODE_W-1:0]  code_l, code_r;
  logic               chg_l, chg_r;
  word_t              vol_words [MAX_PUSH];
  logic [PUSH_CW-1:0] vol_n;

  vol_map #(
    .STEP_W(STEP_W), .STEP_FULL(STEP_FULL), .PB_OFFSET(PB_OFFSET),
    .CAP_OFFSET(CAP_OFFSET), .FIELD_W(FIELD_W), .CODE_W(CODE_W)
  ) u_map (
    .path   (vol_wr_path),
    .step_l (vol_wr_left),
    .step_r (vol_wr_right),
    .cur_l  (shadow[vol_base][CODE_W-1:0]),
    .cur_r  (shadow[vol_base_r][CODE_W-1:0]),
    .addr_l (FIELD_W'(vol_base)),
    .code_l (code_l),
    .code_r (code_r),
    .chg_l  (chg_l),
    .chg_r  (chg_r),
    .words  (vol_words),
    .n_words(vol_n)
  );

  // queue push selection
  logic [PUSH_CW-1:0] push_n;
  word_t              push_words [MAX_PUSH];

  always_comb begin
    push_n = '0;
    for (int i = 0; i < MAX_PUSH; i++) push_words[i] = '0;
    if (reg_ok) begin
      push_n        = PUSH_CW'(1);
      push_words[0] = {reg_wr_addr[FIELD_W-1:0], reg_wr_data[REG_W-1:0]};
    end else if (vol_ok) begin
      push_n = vol_n;
      for (int i = 0; i < MAX_PUSH; i++) push_words[i] = vol_words[i];
    end
  end

  // shadow storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) shadow[i] <= '0;
    end else if (reg_ok) begin
      shadow[reg_wr_addr[RIDX_W-1:0]] <= reg_wr_data[REG_W-1:0];
    end else if (vol_ok) begin
      if (chg_l) shadow[vol_base]   <= {1'b0, code_l};
      if (chg_r) shadow[vol_base_r] <= {1'b0, code_r};
    end
  end

  // read-back
  function automatic logic [STEP_W-1:0] to_step(input logic [CODE_W-1:0] c, input logic p);
    int off;
    off = (p == PATH_CAPT) ? CAP_OFFSET : PB_OFFSET;
    return (int'(c) > off) ? STEP_W'(int'(c) - off) : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      vol_rd_left  <= '0;
      vol_rd_right <= '0;
    end else begin
      rd_data      <= (rd_addr < HADDR_W'(NUM_REGS)) ? shadow[rd_addr[RIDX_W-1:0]] : '0;
      vol_rd_left  <= to_step(shadow[rd_vbase][CODE_W-1:0], vol_rd_path);
      vol_rd_right <= to_step(shadow[RIDX_W'(rd_vbase + 1'b1)][CODE_W-1:0], vol_rd_path);
    end
  end

  // queue and byte engine
  word_t q_head;
  logic  q_empty, q_room, q_pop, tx_active;

  cmd_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_n(push_n), .push_words(push_words),
    .pop(q_pop), .head(q_head), .empty(q_empty), .room(q_room)
  );

  byte_tx u_tx (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_head(q_head), .pop(q_pop),
    .active(tx_active), .tx_byte(tx_byte), .tx_ack(tx_ack)
  );

  assign tx_req = tx_active;
  assign busy   = tx_active || !q_empty;
  assign ready  = q_room;

  a_r4_bad_write_silent: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !busy && !reg_in_range) |=> !busy);
  a_r6_capture_ceiling: assert property (@(posedge clk) disable iff (rst)
    (vol_ok && vol_wr_path == PATH_CAPT) |->
      (int'(code_l) <= CAP_OFFSET + STEP_FULL && int'(code_r) <= CAP_OFFSET + STEP_FULL));
  a_r5_playback_floor: assert property (@(posedge clk) disable iff (rst)
    (vol_ok && vol_wr_path == PATH_PLAY && vol_wr_left != '0) |-> int'(code_l) > PB_OFFSET);
  a_r8_skip_no_push: assert property (@(posedge clk) disable iff (rst)
    (vol_ok && !chg_l && !chg_r && !busy) |=> !busy);
endmodule

// File: tb/codec_shadow_writer_tb.sv
`timescale 1ns/1ps
module codec_shadow_writer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wr_addr = '0;
  logic [16:0] reg_wr_data = '0;
  logic        vol_wr_en = 1'b0;
  logic        vol_wr_path = 1'b0;
  logic [7:0]  vol_wr_left = '0, vol_wr_right = '0;
  logic [7:0]  rd_addr = '0;
  logic [8:0]  rd_data;
  logic        vol_rd_path = 1'b0;
  logic [7:0]  vol_rd_left, vol_rd_right;
  logic        ready, busy, tx_req, tx_ack = 1'b0;
  logic [7:0]  tx_byte;

  always #4 clk = ~clk;

  codec_shadow_writer u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .vol_wr_en(vol_wr_en), .vol_wr_path(vol_wr_path),
    .vol_wr_left(vol_wr_left), .vol_wr_right(vol_wr_right), .rd_addr(rd_addr),
    .rd_data(rd_data), .vol_rd_path(vol_rd_path), .vol_rd_left(vol_rd_left),
    .vol_rd_right(vol_rd_right), .ready(ready), .busy(busy), .tx_req(tx_req),
    .tx_byte(tx_byte), .tx_ack(tx_ack)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] log_b [64];
  int log_n = 0;
  logic [7:0] exp_b [64];
  int exp_n = 0;
  logic [8:0] m_sh [24];
  bit hold_ack = 1'b0;

  // path, left step, right step, expected word count
  localparam logic [19:0] VECS [8] = '{
    {1'b0, 8'd128, 8'd128, 3'd4},
    {1'b0, 8'd128, 8'd128, 3'd0},
    {1'b0, 8'd1,   8'd64,  3'd4},
    {1'b0, 8'd1,   8'd0,   3'd2},
    {1'b1, 8'd128, 8'd0,   3'd1},
    {1'b1, 8'd200, 8'd50,  3'd1},
    {1'b0, 8'd0,   8'd255, 3'd4},
    {1'b1, 8'd0,   8'd1,   3'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // byte sender model: acknowledges each byte one cycle after seeing it
  initial begin
    forever begin
      @(negedge clk);
      if (tx_ack) tx_ack = 1'b0;
      else if (tx_req && !hold_ack) begin
        if (log_n < 64) log_b[log_n] = tx_byte;
        log_n++;
        tx_ack = 1'b1;
      end
    end
  end

  task automatic push_word(input int a, input logic [8:0] d);
    logic [15:0] w;
    w = {a[6:0], d};
    exp_b[exp_n] = w[15:8];
    exp_b[exp_n + 1] = w[7:0];
    exp_n += 2;
  endtask

  task automatic model_reg(input int a, input logic [16:0] d);
    m_sh[a] = d[8:0];
    push_word(a, d[8:0]);
  endtask

  function automatic logic [7:0] code_of(input bit p, input int s);
    int v;
    v = (s > 128) ? 128 : s;
    return (v == 0) ? 8'd0 : 8'(v + (p ? 79 : 127));
  endfunction

  function automatic int step_of(input bit p, input logic [7:0] c);
    int off;
    off = p ? 79 : 127;
    return (int'(c) > off) ? int'(c) - off : 0;
  endfunction

  task automatic model_vol(input bit p, input int l, input int r);
    int base;
    logic [7:0] c;
    base = p ? 14 : 3;
    for (int ch = 0; ch < 2; ch++) begin
      c = code_of(p, ch == 0 ? l : r);
      if (m_sh[base + ch][7:0] != c) begin
        m_sh[base + ch] = {1'b0, c};
        push_word(base + ch, {1'b0, c});
        if (!p) push_word(base + ch, {1'b1, c});
      end
    end
  endtask

  task automatic clear_logs();
    log_n = 0;
    exp_n = 0;
  endtask

  task automatic drive_reg(input int a, input logic [16:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 8'(a); reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic drive_vol(input bit p, input int l, input int r);
    @(negedge clk);
    vol_wr_en = 1'b1; vol_wr_path = p; vol_wr_left = 8'(l); vol_wr_right = 8'(r);
    @(negedge clk);
    vol_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare_bytes(input string req);
    chk(log_n == exp_n, req, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(log_b[i] == exp_b[i], req, log_b[i], exp_b[i]);
  endtask

  task automatic read_reg(input int a, input string req);
    @(negedge clk);
    rd_addr = 8'(a);
    @(negedge clk);
    chk(rd_data == ((a < 24) ? m_sh[a] : 9'd0), req, rd_data, (a < 24) ? m_sh[a] : 0);
  endtask

  task automatic read_vol(input bit p, input string req);
    int base;
    base = p ? 14 : 3;
    @(negedge clk);
    vol_rd_path = p;
    @(negedge clk);
    chk(vol_rd_left == 8'(step_of(p, m_sh[base][7:0])), req, vol_rd_left, step_of(p, m_sh[base][7:0]));
    chk(vol_rd_right == 8'(step_of(p, m_sh[base + 1][7:0])), req, vol_rd_right, step_of(p, m_sh[base + 1][7:0]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 24; i++) m_sh[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && tx_req == 1'b0, "R1 idle", {busy, tx_req}, 0);
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(vol_rd_left == 0 && vol_rd_right == 0, "R1 volume", {vol_rd_left, vol_rd_right}, 0);
    read_reg(3, "R1 register");

    // table of volume requests: R5 R6 R8 R9 R10 R7
    for (int v = 0; v < 8; v++) begin
      bit p;
      int l, r, nw;
      p = VECS[v][19]; l = int'(VECS[v][18:11]); r = int'(VECS[v][10:3]); nw = int'(VECS[v][2:0]);
      clear_logs();
      model_vol(p, l, r);
      drive_vol(p, l, r);
      wait_idle();
      chk(log_n == 2 * nw, p ? "R10 R8 capture words" : "R9 R8 playback words", log_n, 2 * nw);
      compare_bytes(p ? "R6 R10 capture bytes" : "R5 R9 playback bytes");
      read_vol(p, "R7 volume read-back");
      read_reg(p ? 14 : 3, "R9 stored code without latch bit");
    end

    // R3 byte hold with stalled acknowledge, R2 direct write
    clear_logs();
    hold_ack = 1'b1;
    model_reg(5, 17'h001AB);
    drive_reg(5, 17'h001AB);
    repeat (3) @(negedge clk);
    chk(tx_req == 1'b1 && tx_byte == 8'h0B, "R3 hold high byte", tx_byte, 8'h0B);
    repeat (3) @(negedge clk);
    chk(tx_req == 1'b1 && tx_byte == 8'h0B, "R3 still held", tx_byte, 8'h0B);
    chk(busy == 1'b1, "R11 busy while pending", busy, 1);
    hold_ack = 1'b0;
    wait_idle();
    compare_bytes("R3 word order");
    read_reg(5, "R2 read-back");

    // R2 wide data keeps nine bits; top address
    clear_logs();
    model_reg(6, 17'h0F123);
    drive_reg(6, 17'h0F123);
    model_reg(23, 17'h001FF);
    drive_reg(23, 17'h001FF);
    wait_idle();
    compare_bytes("R2 R11 two words in order");
    read_reg(6, "R2 nine bits kept");
    read_reg(23, "R2 top address");
    read_reg(40, "R2 out of range reads zero");

    // R4 ignored writes
    clear_logs();
    drive_reg(24, 17'h00055);
    drive_reg(2, 17'h10000);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && log_n == 0, "R4 nothing sent", log_n, 0);
    read_reg(2, "R4 nothing stored");

    // R7 offset boundary through direct writes
    clear_logs();
    model_reg(3, 17'h0007F);
    drive_reg(3, 17'h0007F);
    model_reg(4, 17'h00080);
    drive_reg(4, 17'h00080);
    wait_idle();
    read_vol(1'b0, "R7 boundary 0x7F and 0x80");
    // R8 with value set by direct write: step 1 equals 0x80 on right
    clear_logs();
    model_vol(1'b0, 0, 1);
    drive_vol(1'b0, 0, 1);
    wait_idle();
    compare_bytes("R8 right skipped after direct write");

    // R12 queue fill with stalled acknowledge
    clear_logs();
    hold_ack = 1'b1;
    for (int i = 0; i < 6; i++) begin
      model_reg(16 + i, 17'(i + 1));
      drive_reg(16 + i, 17'(i + 1));
    end
    @(negedge clk);
    chk(ready == 1'b0, "R12 ready low when nearly full", ready, 0);
    drive_reg(22, 17'h00077);
    hold_ack = 1'b0;
    wait_idle();
    compare_bytes("R12 ignored request absent");
    read_reg(22, "R12 ignored request not stored");
    chk(ready == 1'b1, "R12 ready restored", ready, 1);

    // R12 both enables: register write only
    clear_logs();
    model_reg(18, 17'h00033);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 8'd18; reg_wr_data = 17'h00033;
    vol_wr_en = 1'b1; vol_wr_path = 1'b1; vol_wr_left = 8'd5; vol_wr_right = 8'd5;
    @(negedge clk);
    reg_wr_en = 1'b0; vol_wr_en = 1'b0;
    wait_idle();
    compare_bytes("R12 register write wins");
    read_vol(1'b1, "R12 capture volume untouched");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule